// File: doc/BRIEF.md
# Strap Latch and Frequency Select Control

This block sits next to a clock synthesizer whose frequency-select and output-rate inputs share package pins with clock outputs. During power-on reset the shared pins act as inputs. The block samples five frequency-select straps and one output-rate strap on every reset cycle and holds the value from the last one. Once reset is released, the block raises a drive-enable so the pins can carry clocks. From then on the latched values never change until the next reset.

The synthesizer needs a 5-bit frequency code. The block takes it either from the latched straps or from bits of configuration byte 0, chosen by an override bit in that byte. The same byte also supplies a spread-spectrum enable and a request to put every output in high impedance. Byte 0 resets to zero, so the straps set the frequency at power-up. The block also reports the straps back to the host in inverted form. It does this by overlaying inverted strap bits onto the upper bits of four readback bytes. Host-written data in those bit positions is discarded.

Top module: `strap_fsel_ctrl`

## Requirements
- R1: While `rst` is high, the held strap vector follows the pins on every clock edge. The value held at release is the one sampled on the last edge with `rst` high.
- R2: After `rst` falls, changes on `strap_fs_i` and `strap_rate_i` have no effect on `strap_status_o`, `rate_24m_o` or the strap-derived code.
- R3: `strap_oe_o` is 0 while in reset. It becomes 1 on the first clock edge at which `rst` is low.
- R4: When `cfg0_i[3]` is 0, `fs_code_o` equals the latched straps, with bit n being strap FSn, and `fs_from_reg_o` is 0.
- R5: When `cfg0_i[3]` is 1, `fs_code_o` is {`cfg0_i[2]`, `cfg0_i[7]`, `cfg0_i[6]`, `cfg0_i[5]`, `cfg0_i[4]`}, which are FS4 down to FS0, and `fs_from_reg_o` is 1.
- R6: `spread_en_o` equals `cfg0_i[1]` (1 = ±0.25 % center spread).
- R7: `hiz_all_o` equals `cfg0_i[0]` (1 = tristate all outputs).
- R8: `rate_24m_o` equals the latched rate strap (0 = 48 MHz, 1 = 24 MHz).
- R9: `strap_status_o` bit n (n = 0..4) is the inverse of latched FSn, and bit 5 is the inverse of the latched rate strap.
- R10: `rb_bytes_o` holds byte k in bits 8k+7..8k. The overlays are: byte 0 bit 7 = FS0 inverted, bit 6 = FS1 inverted; byte 1 bit 7 = FS2 inverted; byte 2 bit 7 = FS3 inverted, bit 6 = FS4 inverted; byte 3 bit 7 = rate inverted. All other bits equal `host_rb_i`, and host bits in the overlaid positions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset; straps are sampled while high |
| strap_fs_i | input | 5 | Frequency-select strap pin levels, bit n = FSn |
| strap_rate_i | input | 1 | Output-rate strap pin level |
| cfg0_i | input | 8 | Configuration byte 0 from the register file |
| host_rb_i | input | 32 | Host-held contents of the four readback bytes |
| fs_code_o | output | 5 | Effective frequency-select code |
| fs_from_reg_o | output | 1 | 1 when the code comes from the register |
| spread_en_o | output | 1 | Spread-spectrum enable |
| hiz_all_o | output | 1 | Tristate-all request |
| rate_24m_o | output | 1 | Latched rate strap, 1 = 24 MHz |
| strap_oe_o | output | 1 | Shared pins may be driven as clock outputs |
| strap_status_o | output | 6 | Inverted latched straps, bit 5 = rate |
| rb_bytes_o | output | 32 | Readback bytes with strap overlay |

## Verification
The hardest point to reach is the exact capture edge. The pins must change during reset and again straight after release, and only the value present at the final reset edge may survive. The stimulus does this for all 64 strap patterns. For each one it drives a decoy value and then the intended value inside the reset window, and drives the complement the moment reset drops. It then checks that nothing the decoys or the complement could have reached has moved: the status bits, the rate output, the strap-derived code and the overlaid readback bits.

// File: rtl/strap_fsel_pkg.sv
package strap_fsel_pkg;

    localparam int FS_W     = 5;
    localparam int STRAP_W  = FS_W + 1;
    localparam int BYTE_W   = 8;
    localparam int RB_BYTES = 4;
    localparam int RB_W     = RB_BYTES * BYTE_W;

    // latched strap set; rate sits above the frequency bits
    typedef struct packed {
        logic            rate;
        logic [FS_W-1:0] fs;
    } strap_t;

    // configuration byte 0 layout
    typedef struct packed {
        logic fs3;
        logic fs2;
        logic fs1;
        logic fs0;
        logic use_reg;
        logic fs4;
        logic spread;
        logic hiz;
    } cfg0_t;

    function automatic logic [FS_W-1:0] reg_code(cfg0_t c);
        return {c.fs4, c.fs3, c.fs2, c.fs1, c.fs0};
    endfunction

    // number of overlaid strap bits at the top of readback byte k
    function automatic int rb_cnt(int k);
        case (k)
            0:       return 2;
            1:       return 1;
            2:       return 2;
            default: return 1;
        endcase
    endfunction

    // first inverted-strap index used by readback byte k
    function automatic int rb_base(int k);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++) acc += rb_cnt(i);
        return acc;
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] held_o,
    output logic         drive_o
);
    logic [W-1:0] held_q;
    logic         drive_q;

    // sample on every reset edge, freeze afterwards
    always_ff @(posedge clk) begin
        if (rst) held_q <= pins_i;
    end

    always_ff @(posedge clk) begin
        if (rst) drive_q <= 1'b0;
        else     drive_q <= 1'b1;
    end

    assign held_o  = held_q;
    assign drive_o = drive_q;
endmodule

// File: rtl/fsel_mux.sv
module fsel_mux
    import strap_fsel_pkg::*;
(
    input  cfg0_t           cfg_i,
    input  logic [FS_W-1:0] strap_fs_i,
    output logic [FS_W-1:0] code_o,
    output logic            from_reg_o,
    output logic            spread_o,
    output logic            hiz_o
);
    always_comb begin
        from_reg_o = cfg_i.use_reg;
        code_o     = cfg_i.use_reg ? reg_code(cfg_i) : strap_fs_i;
        spread_o   = cfg_i.spread;
        hiz_o      = cfg_i.hiz;
    end
endmodule

// File: rtl/strap_readback.sv
module strap_readback
    import strap_fsel_pkg::*;
(
    input  logic [STRAP_W-1:0] inv_i,
    input  logic [RB_W-1:0]    host_i,
    output logic [RB_W-1:0]    rb_o
);
    for (genvar k = 0; k < RB_BYTES; k++) begin : g_byte
        localparam int CNT  = rb_cnt(k);
        localparam int BASE = rb_base(k);
        for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
            if (b >= BYTE_W - CNT) begin : g_ovl
                assign rb_o[k*BYTE_W + b] = inv_i[BASE + (BYTE_W - 1 - b)];
            end else begin : g_host
                assign rb_o[k*BYTE_W + b] = host_i[k*BYTE_W + b];
            end
        end
    end
endmodule

// File: rtl/strap_fsel_ctrl.sv
module strap_fsel_ctrl
    import strap_fsel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [FS_W-1:0]     strap_fs_i,
    input  logic                strap_rate_i,
    input  logic [BYTE_W-1:0]   cfg0_i,
    input  logic [RB_W-1:0]     host_rb_i,
    output logic [FS_W-1:0]     fs_code_o,
    output logic                fs_from_reg_o,
    output logic                spread_en_o,
    output logic                hiz_all_o,
    output logic                rate_24m_o,
    output logic                strap_oe_o,
    output logic [STRAP_W-1:0]  strap_status_o,
    output logic [RB_W-1:0]     rb_bytes_o
);
    strap_t pins_s;
    strap_t held_s;
    logic [STRAP_W-1:0] held_v;
    logic [STRAP_W-1:0] inv_v;

    assign pins_s = '{rate: strap_rate_i, fs: strap_fs_i};

    strap_capture #(.W(STRAP_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .pins_i  (pins_s),
        .held_o  (held_v),
        .drive_o (strap_oe_o)
    );

    assign held_s = strap_t'(held_v);
    assign inv_v  = ~held_v;

    fsel_mux u_mux (
        .cfg_i      (cfg0_t'(cfg0_i)),
        .strap_fs_i (held_s.fs),
        .code_o     (fs_code_o),
        .from_reg_o (fs_from_reg_o),
        .spread_o   (spread_en_o),
        .hiz_o      (hiz_all_o)
    );

    strap_readback u_rb (
        .inv_i  (inv_v),
        .host_i (host_rb_i),
        .rb_o   (rb_bytes_o)
    );

    assign rate_24m_o     = held_s.rate;
    assign strap_status_o = inv_v;
endmodule

// File: rtl/strap_fsel_ctrl_chk.sv
module strap_fsel_ctrl_chk
    import strap_fsel_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [BYTE_W-1:0]   cfg0_i,
    input logic [FS_W-1:0]     fs_code_o,
    input logic                fs_from_reg_o,
    input logic                rate_24m_o,
    input logic                strap_oe_o,
    input logic [STRAP_W-1:0]  strap_status_o,
    input logic [RB_W-1:0]     rb_bytes_o
);
    // R2: held straps frozen once pins drive
    a_r2_hold_after_release: assert property (@(posedge clk) disable iff (rst)
        strap_oe_o |=> ($stable(strap_status_o) && $stable(rate_24m_o)));

    // R3: pins switch to drive on first edge out of reset
    a_r3_oe_after_release: assert property (@(posedge clk) disable iff (rst)
        !rst |=> strap_oe_o);

    // R4: strap path agrees with the inverted status
    a_r4_strap_code: assert property (@(posedge clk) disable iff (rst)
        !cfg0_i[3] |-> (fs_code_o == ~strap_status_o[FS_W-1:0] && !fs_from_reg_o));

    // R9: rate status bit is inverse of rate output
    a_r9_rate_status: assert property (@(posedge clk) disable iff (rst)
        strap_status_o[FS_W] == !rate_24m_o);

    // R10: rate overlay in readback byte 3 matches status
    a_r10_rb_rate: assert property (@(posedge clk) disable iff (rst)
        rb_bytes_o[RB_W-1] == strap_status_o[FS_W]);
endmodule

bind strap_fsel_ctrl strap_fsel_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg0_i         (cfg0_i),
    .fs_code_o      (fs_code_o),
    .fs_from_reg_o  (fs_from_reg_o),
    .rate_24m_o     (rate_24m_o),
    .strap_oe_o     (strap_oe_o),
    .strap_status_o (strap_status_o),
    .rb_bytes_o     (rb_bytes_o)
);

// File: tb/strap_fsel_ctrl_bench.sv
module strap_fsel_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  strap_fs_i = '0;
    logic        strap_rate_i = 1'b0;
    logic [7:0]  cfg0_i = '0;
    logic [31:0] host_rb_i = '0;
    logic [4:0]  fs_code_o;
    logic        fs_from_reg_o, spread_en_o, hiz_all_o, rate_24m_o, strap_oe_o;
    logic [5:0]  strap_status_o;
    logic [31:0] rb_bytes_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    strap_fsel_ctrl u_strap_fsel_ctrl (
        .clk(clk), .rst(rst), .strap_fs_i(strap_fs_i), .strap_rate_i(strap_rate_i),
        .cfg0_i(cfg0_i), .host_rb_i(host_rb_i), .fs_code_o(fs_code_o),
        .fs_from_reg_o(fs_from_reg_o), .spread_en_o(spread_en_o), .hiz_all_o(hiz_all_o),
        .rate_24m_o(rate_24m_o), .strap_oe_o(strap_oe_o),
        .strap_status_o(strap_status_o), .rb_bytes_o(rb_bytes_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rb(input logic [5:0] p, input logic [31:0] h);
        logic [5:0] n;
        n = ~p;
        return {n[5], h[30:24], n[3], n[4], h[21:16], n[2], h[14:8], n[0], n[1], h[5:0]};
    endfunction

    task automatic drive_pins(input logic [5:0] v);
        strap_fs_i   = v[4:0];
        strap_rate_i = v[5];
    endtask

    initial begin
        // reset state
        @(negedge clk);
        drive_pins(6'h2A);
        @(negedge clk);
        chk("R3 reset oe", {31'b0, strap_oe_o}, 32'd0);
        chk("R1 follow in reset", {26'b0, strap_status_o}, {26'b0, ~6'h2A});

        for (int p = 0; p < 64; p++) begin
            logic [5:0] pv;
            pv = p[5:0];
            @(negedge clk);
            rst = 1'b1;
            cfg0_i = 8'h00;
            drive_pins(pv ^ 6'h15);
            @(negedge clk);
            chk("R1 decoy tracked", {26'b0, strap_status_o}, {26'b0, ~(pv ^ 6'h15)});
            drive_pins(pv);
            @(negedge clk);
            chk("R3 oe low in reset", {31'b0, strap_oe_o}, 32'd0);
            rst = 1'b0;
            drive_pins(~pv);
            @(negedge clk);
            chk("R3 oe after release", {31'b0, strap_oe_o}, 32'd1);
            chk("R1 R9 status", {26'b0, strap_status_o}, {26'b0, ~pv});
            chk("R8 rate", {31'b0, rate_24m_o}, {31'b0, pv[5]});
            chk("R4 strap code", {26'b0, fs_from_reg_o, fs_code_o}, {27'b0, pv[4:0]});
            drive_pins(pv ^ 6'h3F);
            @(negedge clk);
            drive_pins(pv ^ 6'h0C);
            @(negedge clk);
            chk("R2 status hold", {26'b0, strap_status_o}, {26'b0, ~pv});
            chk("R2 code hold", {27'b0, fs_code_o}, {27'b0, pv[4:0]});
            chk("R2 R8 rate hold", {31'b0, rate_24m_o}, {31'b0, pv[5]});
            host_rb_i = 32'hFFFF_FFFF;
            #1 chk("R10 rb ones", rb_bytes_o, exp_rb(pv, 32'hFFFF_FFFF));
            host_rb_i = 32'h0000_0000;
            #1 chk("R10 rb zeros", rb_bytes_o, exp_rb(pv, 32'h0));
            host_rb_i = 32'h9E37_79B9 ^ {p[7:0], p[7:0], p[7:0], p[7:0]};
            #1 chk("R10 rb mixed", rb_bytes_o, exp_rb(pv, host_rb_i));
        end

        // configuration sweep with last latched pattern 6'h3F
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cv;
            logic [4:0] ec;
            cv = c[7:0];
            @(negedge clk);
            cfg0_i = cv;
            #1;
            ec = cv[3] ? {cv[2], cv[7], cv[6], cv[5], cv[4]} : 5'h1F;
            if (cv[3]) chk("R5 reg code", {26'b0, fs_from_reg_o, fs_code_o}, {26'b0, 1'b1, ec});
            else       chk("R4 strap code", {26'b0, fs_from_reg_o, fs_code_o}, {26'b0, 1'b0, ec});
            chk("R6 spread", {31'b0, spread_en_o}, {31'b0, cv[1]});
            chk("R7 hiz", {31'b0, hiz_all_o}, {31'b0, cv[0]});
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule